// File: doc/BRIEF.md
# Parallel SAR Converter Host Sequencer

This block sits between a synchronous system domain and an external 16-bit successive-approximation converter with a parallel data bus. It produces the converter's conversion clock by dividing the system clock. At a fixed frame of 20 conversion-clock periods it issues an active-low start pulse. It then watches the converter's busy flag, and once the conversion is over it runs an active-low select and read-strobe sequence to fetch the code. The code is straight binary and is passed through without sign handling.

The read runs in one of two ways. In wide mode a single strobe takes all 16 lanes. In split mode two strobes read only the low 8 lanes: the half-select line is low for the upper byte and high for the lower byte. Every strobe width and gap is a whole number of system cycles, rounded up from the nanosecond minimums by parameters. The assembled code leaves on a one-cycle valid pulse. A sticky flag records any frame boundary that arrives while the previous sample is still in flight.

Top module: `sar_adc_host`

## Requirements
- R1: While synchronous reset is high, the conversion clock is low; start, select and read are high; the half-select, valid and overrun outputs are low.
- R2: The conversion clock is high and low for `ceil(SYS_MHZ/(2*CCLK_MHZ))` system cycles each, 3 at the defaults. It starts low on the first cycle after reset and keeps that phase relation from then on.
- R3: A frame is 20 conversion-clock periods, 120 system cycles at the defaults. Start goes low for `ceil(20 ns)` cycles (1 cycle at the defaults) at the first cycle of each frame, while the conversion clock is low. The first start comes one frame after reset is released.
- R4: Select is low from the cycle start falls until the cycle the valid pulse is given, so it covers every start and read strobe. It is high at all other times.
- R5: A read begins only after busy has been seen high and then low. The read strobe first falls 2 cycles after the first cycle in which busy is sampled low.
- R6: Each read strobe stays low for `ceil(50 ns)` cycles (3 at the defaults). Between the two strobes of a split read it stays high for `ceil(20 ns)` cycles (1 at the defaults).
- R7: Split mode (`split_read`=1) uses two strobes. The half-select line is 0 for the first strobe, which gives the upper byte, and 1 for the second, which gives the lower byte. Both bytes are taken from data lanes 7..0, and lanes 15..8 are ignored. The half-select line changes only while the strobe is high.
- R8: Wide mode (`split_read`=0) uses one strobe with the half-select line held at 0 and takes all 16 lanes as the code. The mode is sampled when busy is seen low, so a change during the conversion applies to that conversion's read.
- R9: `smp_valid` is high for exactly one cycle, 6 cycles (wide) or 10 cycles (split) after busy is first driven low, and `smp_data` then carries the converted code unchanged.
- R10: If a frame boundary arrives while the previous conversion or read is still running, that frame's start is skipped and `overrun` goes high and stays high until reset. The pending read still completes normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| split_read | input | 1 | 1: two 8-bit reads, 0: one 16-bit read |
| adc_busy | input | 1 | Converter busy flag |
| adc_db | input | 16 | Converter parallel data bus |
| adc_cclk | output | 1 | Generated conversion clock |
| adc_start_n | output | 1 | Convert start, active low |
| adc_cs_n | output | 1 | Converter select, active low |
| adc_rd_n | output | 1 | Read strobe, active low |
| adc_hilo | output | 1 | Half select: 0 upper byte, 1 lower byte |
| smp_valid | output | 1 | One-cycle pulse with a new sample |
| smp_data | output | 16 | Assembled straight-binary sample |
| overrun | output | 1 | Sticky frame overrun flag |

## Verification
A wrong divider or frame count shows as a mismatch on the conversion clock or the start pin within one half period or one frame. A mistake in the read sequencer moves or stretches the read strobe or the half-select line, and that shows in the same cycle against the per-cycle model. A slip in byte assembly shows as a wrong code or a misplaced valid pulse at the end of that frame's read. Overrun handling is exercised by stretching one conversion past a frame boundary, so a wrong skip or a flag that does not stay set shows on the next start or on the flag.

// File: rtl/sar_host_pkg.sv
package sar_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONV,
        ST_SETUP,
        ST_RDLO,
        ST_RDHI
    } seq_state_t;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_frame_timer.sv
module sar_frame_timer #(
    parameter int HALF_CYC    = 3,
    parameter int FRAME_CCLKS = 20
) (
    input  logic clk,
    input  logic rst,
    output logic cclk_o,
    output logic frame_wrap_o
);
    localparam int FRAME_CYC = FRAME_CCLKS * 2 * HALF_CYC;
    localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam int FW = $clog2(FRAME_CYC);

    typedef struct packed {
        logic [HW-1:0] hc;
        logic          cclk;
        logic [FW-1:0] fr;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.hc == HW'(HALF_CYC - 1)) begin
            tmr_d.hc   = '0;
            tmr_d.cclk = ~tmr_q.cclk;
        end else begin
            tmr_d.hc = tmr_q.hc + 1'b1;
        end
        if (tmr_q.fr == FW'(FRAME_CYC - 1)) tmr_d.fr = '0;
        else                                tmr_d.fr = tmr_q.fr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tmr_q <= '0;
        else     tmr_q <= tmr_d;
    end

    assign cclk_o       = tmr_q.cclk;
    assign frame_wrap_o = (tmr_q.fr == FW'(FRAME_CYC - 1));

    // the frame ends on the high half of the conversion clock
    AST_WRAP_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
        frame_wrap_o |-> cclk_o) else $error("wrap outside high phase"); // R3

endmodule

// File: rtl/sar_read_seq.sv
module sar_read_seq
    import sar_host_pkg::*;
#(
    parameter int DW        = 16,
    parameter int START_CYC = 1,
    parameter int RDLO_CYC  = 3,
    parameter int RDHI_CYC  = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_wrap_i,
    input  logic          split_i,
    input  logic          busy_i,
    input  logic [DW-1:0] db_i,
    output logic          start_n_o,
    output logic          cs_n_o,
    output logic          rd_n_o,
    output logic          hilo_o,
    output logic          valid_o,
    output logic [DW-1:0] data_o,
    output logic          ovr_o
);
    localparam int HB = DW / 2;
    localparam int CW = $clog2(max3(START_CYC, RDLO_CYC, RDHI_CYC) + 1);

    typedef struct packed {
        seq_state_t    st;
        logic [CW-1:0] cnt;
        logic          seen;
        logic          split;
        logic          upper;
        logic          start_n;
        logic          cs_n;
        logic          rd_n;
        logic          hilo;
        logic          valid;
        logic [DW-1:0] asm_w;
        logic [DW-1:0] data;
        logic          ovr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (frame_wrap_i && s_q.st != ST_IDLE) s_d.ovr = 1'b1;
        unique case (s_q.st)
            ST_IDLE: begin
                if (frame_wrap_i) begin
                    s_d.st      = ST_CONV;
                    s_d.start_n = 1'b0;
                    s_d.cs_n    = 1'b0;
                    s_d.cnt     = CW'(START_CYC - 1);
                    s_d.seen    = 1'b0;
                end
            end
            ST_CONV: begin
                if (!s_q.start_n) begin
                    if (s_q.cnt == '0) s_d.start_n = 1'b1;
                    else               s_d.cnt     = s_q.cnt - 1'b1;
                end
                if (busy_i) s_d.seen = 1'b1;
                if (s_q.seen && !busy_i && s_q.start_n) begin
                    s_d.st    = ST_SETUP;
                    s_d.split = split_i;
                    s_d.upper = 1'b1;
                    s_d.hilo  = 1'b0;
                end
            end
            ST_SETUP: begin
                s_d.st   = ST_RDLO;
                s_d.rd_n = 1'b0;
                s_d.cnt  = CW'(RDLO_CYC - 1);
            end
            ST_RDLO: begin
                if (s_q.cnt == '0) begin
                    if (!s_q.split)    s_d.asm_w           = db_i;
                    else if (s_q.upper) s_d.asm_w[DW-1:HB] = db_i[HB-1:0];
                    else               s_d.asm_w[HB-1:0]   = db_i[HB-1:0];
                    s_d.rd_n = 1'b1;
                    s_d.st   = ST_RDHI;
                    s_d.cnt  = CW'(RDHI_CYC - 1);
                    if (s_q.split && s_q.upper) s_d.hilo = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_RDHI: begin
                if (s_q.cnt == '0) begin
                    if (s_q.split && s_q.upper) begin
                        s_d.upper = 1'b0;
                        s_d.st    = ST_RDLO;
                        s_d.rd_n  = 1'b0;
                        s_d.cnt   = CW'(RDLO_CYC - 1);
                    end else begin
                        s_d.st    = ST_IDLE;
                        s_d.cs_n  = 1'b1;
                        s_d.hilo  = 1'b0;
                        s_d.valid = 1'b1;
                        s_d.data  = s_q.asm_w;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q         <= '0;
            s_q.st      <= ST_IDLE;
            s_q.start_n <= 1'b1;
            s_q.cs_n    <= 1'b1;
            s_q.rd_n    <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign start_n_o = s_q.start_n;
    assign cs_n_o    = s_q.cs_n;
    assign rd_n_o    = s_q.rd_n;
    assign hilo_o    = s_q.hilo;
    assign valid_o   = s_q.valid;
    assign data_o    = s_q.data;
    assign ovr_o     = s_q.ovr;

    AST_RD_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o || !start_n_o) |-> !cs_n_o) else $error("strobe without select"); // R4
    AST_RD_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n_o) |-> !busy_i) else $error("read while busy"); // R5
    AST_HILO_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o && !$past(rd_n_o)) |-> $stable(hilo_o)) else $error("half select moved"); // R7
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o) else $error("valid longer than one cycle"); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_o |=> ovr_o) else $error("overrun cleared"); // R10

endmodule

// File: rtl/sar_adc_host.sv
module sar_adc_host
    import sar_host_pkg::*;
#(
    parameter int SYS_MHZ     = 50,
    parameter int CCLK_MHZ    = 10,
    parameter int FRAME_CCLKS = 20,
    parameter int RDLO_NS     = 50,
    parameter int RDHI_NS     = 20,
    parameter int START_NS    = 20,
    parameter int DW          = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          split_read,
    input  logic          adc_busy,
    input  logic [DW-1:0] adc_db,
    output logic          adc_cclk,
    output logic          adc_start_n,
    output logic          adc_cs_n,
    output logic          adc_rd_n,
    output logic          adc_hilo,
    output logic          smp_valid,
    output logic [DW-1:0] smp_data,
    output logic          overrun
);
    localparam int HALF_CYC  = ceil_div(SYS_MHZ, 2 * CCLK_MHZ);
    localparam int RDLO_CYC  = ceil_div(RDLO_NS * SYS_MHZ, 1000);
    localparam int RDHI_CYC  = ceil_div(RDHI_NS * SYS_MHZ, 1000);
    localparam int START_CYC = ceil_div(START_NS * SYS_MHZ, 1000);

    logic frame_wrap;

    sar_frame_timer #(
        .HALF_CYC   (HALF_CYC),
        .FRAME_CCLKS(FRAME_CCLKS)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .cclk_o      (adc_cclk),
        .frame_wrap_o(frame_wrap)
    );

    sar_read_seq #(
        .DW       (DW),
        .START_CYC(START_CYC),
        .RDLO_CYC (RDLO_CYC),
        .RDHI_CYC (RDHI_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_wrap_i(frame_wrap),
        .split_i     (split_read),
        .busy_i      (adc_busy),
        .db_i        (adc_db),
        .start_n_o   (adc_start_n),
        .cs_n_o      (adc_cs_n),
        .rd_n_o      (adc_rd_n),
        .hilo_o      (adc_hilo),
        .valid_o     (smp_valid),
        .data_o      (smp_data),
        .ovr_o       (overrun)
    );

    AST_START_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_start_n) |-> !adc_cclk) else $error("start outside low phase"); // R3

endmodule

// File: tb/sar_adc_host_test.sv
module sar_adc_host_test;
    localparam int HALF  = 3;
    localparam int F     = 120;
    localparam int STW   = 1;
    localparam int RDL   = 3;
    localparam int RDH   = 1;
    localparam int LATW  = 2 + RDL + RDH;
    localparam int LATS  = 2 + 2 * (RDL + RDH);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic split_read = 1'b1;
    logic adc_busy = 1'b0;
    logic [15:0] adc_db = 16'hDEAD;
    logic adc_cclk, adc_start_n, adc_cs_n, adc_rd_n, adc_hilo, smp_valid, overrun;
    logic [15:0] smp_data;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    sar_adc_host uut (
        .clk(clk), .rst(rst), .split_read(split_read), .adc_busy(adc_busy),
        .adc_db(adc_db), .adc_cclk(adc_cclk), .adc_start_n(adc_start_n),
        .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n), .adc_hilo(adc_hilo),
        .smp_valid(smp_valid), .smp_data(smp_data), .overrun(overrun)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
        end
    endtask

    function automatic logic [15:0] code_for(input int n);
        case (n)
            0: return 16'h0000;  1: return 16'hFFFF;
            2: return 16'h8001;  3: return 16'h00FF;
            4: return 16'hFF00;  5: return 16'h1234;
            6: return 16'hA5C3;  7: return 16'h7FFE;
            default: return 16'((n * 40503) ^ (n << 7));
        endcase
    endfunction

    function automatic bit split_for(input int fi);
        return !(fi == 3 || fi == 4 || fi == 8 || fi == 11);
    endfunction

    // behavioural model state
    int t, launch_t, fall_t, edges, conv_len, n_code;
    bit in_flight, reading, split_at, busy_drv, prev_cclk, ovr_exp;
    logic [15:0] cur_code;
    logic [15:0] pend[$];

    task automatic model_reset();
        t = 0; launch_t = -1000; fall_t = 0; edges = 0; conv_len = 14;
        in_flight = 0; reading = 0; split_at = 0; busy_drv = 0;
        prev_cclk = 0; ovr_exp = 0; pend.delete();
        adc_busy = 0; adc_db = 16'hDEAD;
    endtask

    task automatic hold_reset(input int cycles);
        rst = 1'b1;
        adc_busy = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check(adc_cclk == 1'b0, "R1 cclk", adc_cclk, 0);
            check({adc_start_n, adc_cs_n, adc_rd_n} == 3'b111, "R1 strobes",
                  {adc_start_n, adc_cs_n, adc_rd_n}, 3'b111);
            check({adc_hilo, smp_valid, overrun} == 3'b000, "R1 flags",
                  {adc_hilo, smp_valid, overrun}, 3'b000);
        end
        model_reset();
        rst = 1'b0;
    endtask

    task automatic step();
        bit exp_cclk, exp_rd_n, exp_hilo, exp_valid, exp_start_n;
        int rel, lat, fi;
        @(posedge clk);
        t++;
        @(negedge clk);
        fi = t / F;
        exp_cclk = ((t / HALF) % 2) == 1;
        check(adc_cclk == exp_cclk, "R2 cclk", adc_cclk, exp_cclk);

        if (t % F == 0) begin
            if (!in_flight) begin
                in_flight = 1; launch_t = t; busy_drv = 1; edges = 0;
                conv_len = (fi == 6) ? 34 : 14;
                cur_code = code_for(n_code); n_code++;
                pend.push_back(cur_code);
            end else begin
                ovr_exp = 1;
            end
        end
        exp_start_n = !((t - launch_t) < STW);
        check(adc_start_n == exp_start_n, "R3 start", adc_start_n, exp_start_n);

        exp_rd_n = 1; exp_hilo = 0; exp_valid = 0;
        lat = split_at ? LATS : LATW;
        if (reading) begin
            rel = t - fall_t;
            if (rel >= 2 && rel < 2 + RDL) exp_rd_n = 0;
            if (split_at && rel >= 2 + RDL + RDH && rel < 2 + 2 * RDL + RDH) exp_rd_n = 0;
            if (split_at && rel >= 2 + RDL && rel < lat) exp_hilo = 1;
            exp_valid = (rel == lat);
        end
        check(adc_rd_n == exp_rd_n, "R5 R6 strobe", adc_rd_n, exp_rd_n);
        check(adc_hilo == exp_hilo, "R7 R8 half select", adc_hilo, exp_hilo);
        check(smp_valid == exp_valid, "R9 valid", smp_valid, exp_valid);
        if (exp_valid) begin
            check(smp_data == pend[0], split_at ? "R7 split data" : "R8 wide data",
                  smp_data, pend[0]);
            void'(pend.pop_front());
            in_flight = 0; reading = 0;
        end
        check(adc_cs_n == !in_flight, "R4 select", adc_cs_n, !in_flight);
        check(overrun == ovr_exp, "R10 overrun", overrun, ovr_exp);

        // converter model
        if (busy_drv && exp_cclk && !prev_cclk) begin
            edges++;
            if (edges == conv_len) begin
                busy_drv = 0; reading = 1; fall_t = t; split_at = split_read;
            end
        end
        prev_cclk = exp_cclk;
        adc_busy = busy_drv;
        if (t % F == 50) split_read = split_for(fi);
        if (!adc_rd_n && !adc_cs_n) begin
            if (split_read) adc_db = {8'h5A, adc_hilo ? cur_code[7:0] : cur_code[15:8]};
            else            adc_db = cur_code;
        end else begin
            adc_db = 16'hDEAD;
        end
    endtask

    initial begin
        n_code = 0;
        cur_code = 16'h0;
        model_reset();
        hold_reset(4);
        while (t < 12 * F + 110) step();
        @(negedge clk);
        hold_reset(3);
        while (t < 4 * F) step();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule